// File: doc/BRIEF.md
# Multi-Digit Seven-Segment Decoder with Zero Suppression

This block turns a row of packed 4-bit codes into seven-segment patterns, one decoder per digit position, for driving a numeric display. Each digit has its own active-low lamp-test and active-low blank controls. The decoders are linked from the most significant position downward by an active-low ripple signal, so that zeros to the left of the first non-zero digit go dark. The least significant digit always shows its value, so a value of zero still reads as a single 0.

Inside each digit, the blank request from outside and the digit's own zero-suppress result are merged by AND into one active-low node. That node both darkens the digit and becomes the ripple output that is passed to the next lower digit. A parameter adds one register stage on every output, which helps timing closure when the display driver sits far away.

Top module: `zs_digit_chain`

## Requirements
- R1: Segment outputs are active-high. For each digit k, seg_o[7k+6] is segment a and seg_o[7k] is segment g. When the digit is lit normally, codes 0 to 9 show the usual numerals. Code 6 has segment a off (0011111) and code 9 has segment d off (1110011).
- R2: When blank_n_i[k] is 0, all seven segments of digit k are 0, whatever the code, lamp-test or ripple input.
- R3: When digit k is not blanked and lamp_test_n_i[k] is 0, all seven of its segments are 1 for any code.
- R4: When lamp-test is 1, the ripple input is 0 and the code is 0000, the digit's segments are all 0 and its ripple output is 0.
- R5: When the ripple input is 1, code 0000 shows a normal zero, a to f on and g off (1111110).
- R6: rbo_n_o[k] is the AND of blank_n_i[k] and the digit's own suppress result, which is active-low. An external blank therefore also drives the ripple output to 0.
- R7: Codes 10 to 15 show fixed patterns, with segments written a to g: 10=0001101, 11=0011001, 12=0100011, 13=1001011, 14=0001111, 15=0000000.
- R8: The ripple output of digit k+1 is the ripple input of digit k. When NUM_DIGITS is greater than 1, the ripple input of digit 0 is tied to 1.
- R9: zs_enable_n_i is the ripple input of the most significant digit. When it is 1, no leading zero is suppressed.
- R10: When OUT_REG is 1, seg_o and rbo_n_o follow the decoded values one clock later. A synchronous active-high rst clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| code_i | input | 4*NUM_DIGITS | Packed codes; digit k at [4k+3:4k], digit NUM_DIGITS-1 most significant |
| lamp_test_n_i | input | NUM_DIGITS | Active-low lamp test per digit |
| blank_n_i | input | NUM_DIGITS | Active-low external blank per digit |
| zs_enable_n_i | input | 1 | Ripple input of the top digit; 0 suppresses leading zeros |
| seg_o | output | 7*NUM_DIGITS | Segments a..g per digit, a at bit 7k+6 |
| rbo_n_o | output | NUM_DIGITS | Active-low ripple output per digit |

## Verification
The top digit is swept through all 16 codes under all eight combinations of lamp-test, ripple input and blank, with the lower digits held at zero. This separates the order in which the controls take effect, and it also shows whether a dark top digit carries suppression down the chain. Directed values such as 0040, 0000, 1000, 0100 and 0909 are applied with suppression both enabled and disabled, which checks where the chain stops blanking and that the last digit always shows. A further arithmetic sweep places a blank and a lamp test in middle positions to check how they interact with the chain. A registered and an unregistered instance are compared against the same bench model, and reset is applied both at the start and in the middle of the run.

// File: rtl/zs_pkg.sv
package zs_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_W  = 7;

  typedef logic [SEG_W-1:0] seg_t;

  localparam seg_t SEG_ALL = '1;

  // Segment pattern for one code, bit 6 = a ... bit 0 = g.
  function automatic seg_t glyph(input logic [CODE_W-1:0] c);
    seg_t s;
    case (c)
      4'd0:    s = 7'b1111110;
      4'd1:    s = 7'b0110000;
      4'd2:    s = 7'b1101101;
      4'd3:    s = 7'b1111001;
      4'd4:    s = 7'b0110011;
      4'd5:    s = 7'b1011011;
      4'd6:    s = 7'b0011111;
      4'd7:    s = 7'b1110000;
      4'd8:    s = 7'b1111111;
      4'd9:    s = 7'b1110011;
      4'd10:   s = 7'b0001101;
      4'd11:   s = 7'b0011001;
      4'd12:   s = 7'b0100011;
      4'd13:   s = 7'b1001011;
      4'd14:   s = 7'b0001111;
      default: s = 7'b0000000;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/zs_digit_dec.sv
module zs_digit_dec
  import zs_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              lt_n,
  input  logic              rbi_n,
  input  logic              bl_n,
  output seg_t              seg,
  output logic              node_n
);
  logic zero_code;
  logic suppress;

  assign zero_code = (code == '0);
  assign suppress  = lt_n & ~rbi_n & zero_code;
  // Wired-AND of the external blank and the internal ripple output.
  assign node_n    = bl_n & ~suppress;

  always_comb begin
    if (!node_n)     seg = '0;
    else if (!lt_n)  seg = SEG_ALL;
    else             seg = glyph(code);
  end
endmodule

// File: rtl/zs_out_stage.sv
module zs_out_stage #(
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
      end
    end else begin : g_pass
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/zs_digit_chain.sv
module zs_digit_chain
  import zs_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter bit OUT_REG    = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_DIGITS*CODE_W-1:0] code_i,
  input  logic [NUM_DIGITS-1:0]        lamp_test_n_i,
  input  logic [NUM_DIGITS-1:0]        blank_n_i,
  input  logic                         zs_enable_n_i,
  output logic [NUM_DIGITS*SEG_W-1:0]  seg_o,
  output logic [NUM_DIGITS-1:0]        rbo_n_o
);
  localparam int SEG_BITS = NUM_DIGITS * SEG_W;
  localparam int OUT_W    = SEG_BITS + NUM_DIGITS;
  localparam int MSD      = NUM_DIGITS - 1;

  // Named per-digit events, visible to the bound checker.
  logic [NUM_DIGITS-1:0][SEG_W-1:0] dig_seg;
  logic [NUM_DIGITS-1:0]            dig_node;
  logic [NUM_DIGITS-1:0]            dig_rbi;

  generate
    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dig
      if (k == MSD) begin : g_top
        assign dig_rbi[k] = zs_enable_n_i;
      end else if (k == 0) begin : g_lsd
        assign dig_rbi[k] = 1'b1;
      end else begin : g_mid
        assign dig_rbi[k] = dig_node[k+1];
      end

      zs_digit_dec u_dec (
        .code   (code_i[k*CODE_W +: CODE_W]),
        .lt_n   (lamp_test_n_i[k]),
        .rbi_n  (dig_rbi[k]),
        .bl_n   (blank_n_i[k]),
        .seg    (dig_seg[k]),
        .node_n (dig_node[k])
      );
    end
  endgenerate

  logic [OUT_W-1:0] out_d;
  logic [OUT_W-1:0] out_q;

  assign out_d = {dig_seg, dig_node};

  zs_out_stage #(
    .W       (OUT_W),
    .OUT_REG (OUT_REG)
  ) u_out (
    .clk (clk),
    .rst (rst),
    .d   (out_d),
    .q   (out_q)
  );

  assign seg_o   = out_q[OUT_W-1 -: SEG_BITS];
  assign rbo_n_o = out_q[NUM_DIGITS-1:0];
endmodule

// File: rtl/zs_digit_chain_chk.sv
module zs_digit_chain_chk #(
  parameter int NUM_DIGITS = 4,
  parameter bit OUT_REG    = 1'b1
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_DIGITS*4-1:0]      code_i,
  input logic [NUM_DIGITS-1:0]        lamp_test_n_i,
  input logic [NUM_DIGITS-1:0]        blank_n_i,
  input logic [NUM_DIGITS*7-1:0]      seg_o,
  input logic [NUM_DIGITS-1:0]        rbo_n_o,
  input logic [NUM_DIGITS*7-1:0]      dig_seg,
  input logic [NUM_DIGITS-1:0]        dig_node,
  input logic [NUM_DIGITS-1:0]        dig_rbi
);
  generate
    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_k
      p_blank_wins_r2: assert property (@(posedge clk) disable iff (rst)
        !blank_n_i[k] |-> (dig_seg[k*7 +: 7] == 7'd0) && !dig_node[k]);

      p_lamp_on_r3: assert property (@(posedge clk) disable iff (rst)
        (blank_n_i[k] && !lamp_test_n_i[k]) |-> (dig_seg[k*7 +: 7] == 7'h7F));

      p_zero_dark_r4: assert property (@(posedge clk) disable iff (rst)
        (lamp_test_n_i[k] && !dig_rbi[k] && code_i[k*4 +: 4] == 4'd0)
          |-> (dig_seg[k*7 +: 7] == 7'd0) && !dig_node[k]);

      p_zero_shown_r5: assert property (@(posedge clk) disable iff (rst)
        (blank_n_i[k] && lamp_test_n_i[k] && dig_rbi[k] && code_i[k*4 +: 4] == 4'd0)
          |-> (dig_seg[k*7 +: 7] == 7'b1111110));

      p_eight_full_r1: assert property (@(posedge clk) disable iff (rst)
        (dig_node[k] && code_i[k*4 +: 4] == 4'd8) |-> (dig_seg[k*7 +: 7] == 7'h7F));

      if (k > 0 && k < NUM_DIGITS - 1) begin : g_chain
        p_ripple_down_r8: assert property (@(posedge clk) disable iff (rst)
          (!dig_node[k+1] && lamp_test_n_i[k] && code_i[k*4 +: 4] == 4'd0)
            |-> (dig_seg[k*7 +: 7] == 7'd0));
      end

      if (!OUT_REG) begin : g_comb
        p_blank_port_r6: assert property (@(posedge clk) disable iff (rst)
          !blank_n_i[k] |-> (seg_o[k*7 +: 7] == 7'd0) && !rbo_n_o[k]);
      end
    end

    if (OUT_REG) begin : g_regchk
      p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (seg_o == $past(dig_seg)) && (rbo_n_o == $past(dig_node)));

      p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (seg_o == '0) && (rbo_n_o == '0));
    end
  endgenerate
endmodule

bind zs_digit_chain zs_digit_chain_chk #(
  .NUM_DIGITS (NUM_DIGITS),
  .OUT_REG    (OUT_REG)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .code_i        (code_i),
  .lamp_test_n_i (lamp_test_n_i),
  .blank_n_i     (blank_n_i),
  .seg_o         (seg_o),
  .rbo_n_o       (rbo_n_o),
  .dig_seg       (dig_seg),
  .dig_node      (dig_node),
  .dig_rbi       (dig_rbi)
);

// File: tb/zs_digit_chain_tb.sv
module zs_digit_chain_tb;
  localparam int N = 4;

  // Per-segment lit masks: bit c set when code c lights that segment.
  localparam logic [15:0] M_A = 16'h23AD;
  localparam logic [15:0] M_B = 16'h139F;
  localparam logic [15:0] M_C = 16'h0BFB;
  localparam logic [15:0] M_D = 16'h6D6D;
  localparam logic [15:0] M_E = 16'h4545;
  localparam logic [15:0] M_F = 16'h7371;
  localparam logic [15:0] M_G = 16'h7F7C;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [4*N-1:0] code = '0;
  logic [N-1:0] lt_n = '1;
  logic [N-1:0] bl_n = '1;
  logic         zs_n = 1'b0;
  logic [7*N-1:0] seg_r, seg_c;
  logic [N-1:0] rbo_r, rbo_c;

  int checks = 0;
  int errors = 0;

  logic [6:0] exp_seg [N];
  logic       exp_rbo [N];
  string      exp_tag [N];

  always #10ns clk = ~clk;

  zs_digit_chain #(.NUM_DIGITS(N), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst(rst), .code_i(code), .lamp_test_n_i(lt_n),
    .blank_n_i(bl_n), .zs_enable_n_i(zs_n), .seg_o(seg_r), .rbo_n_o(rbo_r));

  zs_digit_chain #(.NUM_DIGITS(N), .OUT_REG(1'b0)) u_comb (
    .clk(clk), .rst(rst), .code_i(code), .lamp_test_n_i(lt_n),
    .blank_n_i(bl_n), .zs_enable_n_i(zs_n), .seg_o(seg_c), .rbo_n_o(rbo_c));

  function automatic logic [6:0] lut(input int c);
    return {M_A[c], M_B[c], M_C[c], M_D[c], M_E[c], M_F[c], M_G[c]};
  endfunction

  task automatic model();
    logic rip = zs_n;
    for (int k = N - 1; k >= 0; k--) begin
      int  c = int'(code[4*k +: 4]);
      logic sup, node;
      if (k == 0 && N > 1) rip = 1'b1;
      sup  = lt_n[k] && !rip && (c == 0);
      node = bl_n[k] && !sup;
      exp_seg[k] = !node ? 7'd0 : (!lt_n[k] ? 7'h7F : lut(c));
      exp_rbo[k] = node;
      if (!bl_n[k])      exp_tag[k] = "R2";
      else if (sup)      exp_tag[k] = (k == N - 1) ? "R4" : "R8";
      else if (!lt_n[k]) exp_tag[k] = "R3";
      else if (c == 0)   exp_tag[k] = "R5";
      else if (c < 10)   exp_tag[k] = "R1";
      else               exp_tag[k] = "R7";
      rip = node;
    end
  endtask

  task automatic cmp(input string tag, input string which, input int k,
                     input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s digit %0d: actual %b expected %b", tag, which, k, act, exp);
    end
  endtask

  task automatic step_check(input string tag_over);
    @(posedge clk);
    @(negedge clk);
    model();
    for (int k = 0; k < N; k++) begin
      string t = (tag_over == "") ? exp_tag[k] : tag_over;
      cmp(t, "comb seg", k, seg_c[7*k +: 7], exp_seg[k]);
      cmp("R6", "comb rbo", k, {6'd0, rbo_c[k]}, {6'd0, exp_rbo[k]});
      cmp({t, "/R10"}, "reg seg", k, seg_r[7*k +: 7], exp_seg[k]);
      cmp("R10", "reg rbo", k, {6'd0, rbo_r[k]}, {6'd0, exp_rbo[k]});
    end
  endtask

  task automatic reset_check();
    for (int k = 0; k < N; k++) begin
      cmp("R10", "reset seg", k, seg_r[7*k +: 7], 7'd0);
      cmp("R10", "reset rbo", k, {6'd0, rbo_r[k]}, 7'd0);
    end
  endtask

  task automatic put(input logic [15:0] v, input logic z);
    code = v[4*N-1:0];
    zs_n = z;
  endtask

  initial begin
    #4ms;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // Reset state of the registered outputs (R10).
    code = 16'h8888;
    lt_n = '0;
    repeat (3) @(negedge clk);
    reset_check();
    rst = 1'b0;
    step_check("");

    // Top digit: every code under every lamp/ripple/blank combination.
    for (int c = 0; c < 16; c++) begin
      for (int m = 0; m < 8; m++) begin
        @(negedge clk);
        code = '0;
        code[4*(N-1) +: 4] = 4'(c);
        lt_n = '1;
        bl_n = '1;
        lt_n[N-1] = m[0];
        zs_n = m[1];
        bl_n[N-1] = m[2];
        step_check("");
      end
    end

    // Multi-digit leading-zero handling (R8 suppression on, R9 off).
    lt_n = '1;
    bl_n = '1;
    for (int z = 0; z < 2; z++) begin
      string t = (z == 1) ? "R9" : "R8";
      @(negedge clk); put(16'h0040, z[0]); step_check(t);
      @(negedge clk); put(16'h0000, z[0]); step_check(t);
      @(negedge clk); put(16'h1000, z[0]); step_check(t);
      @(negedge clk); put(16'h0100, z[0]); step_check(t);
      @(negedge clk); put(16'h0909, z[0]); step_check(t);
      @(negedge clk); put(16'h0006, z[0]); step_check(t);
    end

    // Lamp test on one suppressed digit at a time.
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      put(16'h0000, 1'b0);
      lt_n = ~(N'(1) << k);
      step_check("");
    end
    lt_n = '1;

    // Arithmetic sweep with mid-chain blank and lamp test.
    for (int v = 0; v < 512; v++) begin
      logic [15:0] w = '0;
      @(negedge clk);
      for (int k = 0; k < N; k++)
        if (v[k]) w[4*k +: 4] = 4'((v >> 4) + k);
      put(w, (v % 3) == 0);
      bl_n = v[8] ? 4'b1011 : 4'b1111;
      lt_n = (v[7:4] == 4'd5) ? 4'b1101 : 4'b1111;
      step_check("");
    end

    // Reset in mid-run clears the registered outputs (R10).
    @(negedge clk);
    put(16'h8888, 1'b1);
    lt_n = '1;
    bl_n = '1;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reset_check();
    rst = 1'b0;
    step_check("");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule